// File: doc/BRIEF.md
# Interlaced Field-to-Frame Assembler with Chroma Decimation

This block sits behind a video capture front end that has already split an interlaced 4:2:2 picture into three word streams: luma, blue-difference chroma and red-difference chroma. Each word carries four 8-bit samples. For every accepted word the block produces a byte write address, a write enable and the data for a progressive 4:2:0 frame buffer. Lines of the first field land on the even rows of the frame and lines of the second field on the odd rows, through a luma row stride of two lines. Chroma is kept from the first field only, which halves the chroma row count. Second-field chroma is still accepted, but it is dropped with its write enable held low.

Two frame buffers are used in turn. Each has its own base address per plane, given as configuration inputs. A frame moves through four field contexts (buffer A first field, buffer A second field, buffer B first field, buffer B second field) and then wraps. When the last luma word of a second field is written, the block raises a one-cycle frame interrupt together with the index of the buffer that is now complete and safe to read. No interrupt is raised per line.

A start-of-field marker, tagged with the field identity, restarts every line and word counter. A field whose luma line count is wrong sets a sticky error flag. A frame that carries such an error raises no interrupt and does not advance the buffer index, so the same buffer is filled again. The default geometry is 720x480 with two 240-line fields: 180 luma words and 90 chroma words per line.

Top module: `ffa_field_assembler`

## Requirements
- R1: Every ready output equals `enable`. While `enable` is low, start-of-field markers and input words are ignored and no write enable rises.
- R2: A first-field luma word (`sof_field` = 0) at line L and word W is written to `luma base + (2L)*LS + 4W`, where LS = 4*Y_WORDS bytes.
- R3: A second-field luma word (`sof_field` = 1) at line L and word W is written to `luma base + (2L+1)*LS + 4W`. The field therefore starts one luma line above the first field's start address.
- R4: A first-field chroma word at line L and word W of either plane is written to `plane base + L*CS + 4W`, where CS = 4*C_WORDS bytes.
- R5: Second-field chroma words are accepted, because ready stays high, but their write enable stays low.
- R6: Each write appears on the outputs in the cycle after the clock edge that accepted the word, and the write data equals the input word.
- R7: `frame_irq` is high for exactly one cycle, together with the write of the last luma word of a complete second field. `frame_buf` then gives the index of the buffer just filled.
- R8: The buffer index starts at 0 (A) after reset and toggles once per complete, error-free frame, so buffers are used in the order A, B, A, ...
- R9: A start-of-field marker restarts the line and word counts. The word presented in the same cycle as the marker is word 0 of line 0 of the new field.
- R10: `field_err` is sticky and set in either of two cases. The first is a start-of-field marker arriving before the previous field has delivered all luma lines (a short field). The second is a luma word arriving after the field is complete (a long field). A frame with such an error gives no interrupt and no buffer advance.
- R11: Words that arrive before the first start-of-field marker, and words beyond the field's last line, cause no write.
- R12: After reset, all write enables, `frame_irq` and `field_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; gates acceptance |
| y_base_a | input | ADDR_W | Luma base, buffer A |
| y_base_b | input | ADDR_W | Luma base, buffer B |
| cb_base_a | input | ADDR_W | Blue chroma base, buffer A |
| cb_base_b | input | ADDR_W | Blue chroma base, buffer B |
| cr_base_a | input | ADDR_W | Red chroma base, buffer A |
| cr_base_b | input | ADDR_W | Red chroma base, buffer B |
| sof | input | 1 | Start-of-field marker |
| sof_field | input | 1 | Field identity at the marker (0 first, 1 second) |
| y_valid | input | 1 | Luma word valid |
| y_data | input | DATA_W | Luma word |
| y_ready | output | 1 | Luma ready |
| cb_valid | input | 1 | Blue chroma word valid |
| cb_data | input | DATA_W | Blue chroma word |
| cb_ready | output | 1 | Blue chroma ready |
| cr_valid | input | 1 | Red chroma word valid |
| cr_data | input | DATA_W | Red chroma word |
| cr_ready | output | 1 | Red chroma ready |
| y_we | output | 1 | Luma write enable |
| y_addr | output | ADDR_W | Luma byte address |
| y_wdata | output | DATA_W | Luma write data |
| cb_we | output | 1 | Blue chroma write enable |
| cb_addr | output | ADDR_W | Blue chroma byte address |
| cb_wdata | output | DATA_W | Blue chroma write data |
| cr_we | output | 1 | Red chroma write enable |
| cr_addr | output | ADDR_W | Red chroma byte address |
| cr_wdata | output | DATA_W | Red chroma write data |
| frame_irq | output | 1 | One-cycle frame-complete pulse |
| frame_buf | output | 1 | Buffer index completed, valid with frame_irq |
| field_err | output | 1 | Sticky field length error |

## Verification
Every write, and the frame interrupt that rides on the last luma write, is due exactly one cycle after the rising edge that accepted the word. The error flag is due one cycle after the marker or the extra word that caused it. The driver stamps each expected write with the cycle number of the edge that accepts it plus one. The monitor samples on the falling edge and compares the cycle, address, data and interrupt fields, so a write that is early, late, missing or extra is reported. Error-flag and idle checks are also taken on a falling edge, after the edge that should have changed them.

// File: rtl/ffa_pkg.sv
package ffa_pkg;
    typedef enum logic {
        FIELD_ONE = 1'b0,
        FIELD_TWO = 1'b1
    } field_e;

    localparam int unsigned CHROMA_PLANES = 2;
endpackage

// File: rtl/ffa_line_walker.sv
// Word/line position counter for one plane within one field.
module ffa_line_walker #(
    parameter int unsigned WORDS = 180,
    parameter int unsigned LINES = 240,
    localparam int unsigned WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int unsigned LINE_W = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic [WORD_W-1:0] cur_word,
    output logic [LINE_W-1:0] cur_line,
    output logic              cur_done,
    output logic              done_raw
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LINE_W-1:0] line;
        logic              done;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_t base;
        base     = restart ? '0 : pos_q;
        cur_word = base.word;
        cur_line = base.line;
        cur_done = base.done;
        pos_d    = base;
        if (step && !base.done) begin
            if (base.word == WORD_W'(WORDS - 1)) begin
                pos_d.word = '0;
                pos_d.line = base.line + 1'b1;
                if (base.line == LINE_W'(LINES - 1)) begin
                    pos_d.done = 1'b1;
                end
            end else begin
                pos_d.word = base.word + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign done_raw = pos_q.done;

    // R9
    word_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pos_q.word) < WORDS);

    // R11
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q.done && !restart) |=> pos_q.done);
endmodule

// File: rtl/ffa_frame_ctl.sv
// Field context, ping-pong buffer index, frame interrupt and error flag.
module ffa_frame_ctl import ffa_pkg::*; (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sof_take,
    input  field_e sof_field,
    input  logic   y_done_raw,
    input  logic   y_overrun,
    input  logic   y_finish,
    output field_e cur_field,
    output logic   cur_active,
    output logic   buf_sel,
    output logic   irq,
    output logic   irq_buf,
    output logic   err
);
    typedef struct packed {
        field_e field;
        logic   active;
        logic   bsel;
        logic   bad;
        logic   irq;
        logic   irq_buf;
        logic   err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        logic short_field;
        ctl_d       = ctl_q;
        ctl_d.irq   = 1'b0;
        cur_field   = ctl_q.field;
        cur_active  = ctl_q.active;
        short_field = ctl_q.active && !y_done_raw;
        if (sof_take) begin
            if (short_field) begin
                ctl_d.err = 1'b1;
            end
            ctl_d.bad    = (sof_field == FIELD_ONE) ? 1'b0 : (ctl_q.bad | short_field);
            ctl_d.active = 1'b1;
            ctl_d.field  = sof_field;
            cur_field    = sof_field;
            cur_active   = 1'b1;
        end
        if (y_overrun) begin
            ctl_d.err = 1'b1;
            ctl_d.bad = 1'b1;
        end
        if (y_finish && cur_field == FIELD_TWO && !ctl_d.bad) begin
            ctl_d.irq     = 1'b1;
            ctl_d.irq_buf = ctl_q.bsel;
            ctl_d.bsel    = ~ctl_q.bsel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{field: FIELD_ONE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign buf_sel = ctl_q.bsel;
    assign irq     = ctl_q.irq;
    assign irq_buf = ctl_q.irq_buf;
    assign err     = ctl_q.err;

    // R7
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.irq |=> !ctl_q.irq);

    // R8
    buf_moves_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q.bsel) |-> ctl_q.irq);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.err |=> ctl_q.err);

    // R10
    irq_only_when_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.bad && !sof_take) |=> !ctl_q.irq);
endmodule

// File: rtl/ffa_field_assembler.sv
module ffa_field_assembler import ffa_pkg::*; #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned Y_WORDS = 180,
    parameter int unsigned C_WORDS = 90,
    parameter int unsigned LINES   = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] y_base_a,
    input  logic [ADDR_W-1:0] y_base_b,
    input  logic [ADDR_W-1:0] cb_base_a,
    input  logic [ADDR_W-1:0] cb_base_b,
    input  logic [ADDR_W-1:0] cr_base_a,
    input  logic [ADDR_W-1:0] cr_base_b,
    input  logic              sof,
    input  logic              sof_field,
    input  logic              y_valid,
    input  logic [DATA_W-1:0] y_data,
    output logic              y_ready,
    input  logic              cb_valid,
    input  logic [DATA_W-1:0] cb_data,
    output logic              cb_ready,
    input  logic              cr_valid,
    input  logic [DATA_W-1:0] cr_data,
    output logic              cr_ready,
    output logic              y_we,
    output logic [ADDR_W-1:0] y_addr,
    output logic [DATA_W-1:0] y_wdata,
    output logic              cb_we,
    output logic [ADDR_W-1:0] cb_addr,
    output logic [DATA_W-1:0] cb_wdata,
    output logic              cr_we,
    output logic [ADDR_W-1:0] cr_addr,
    output logic [DATA_W-1:0] cr_wdata,
    output logic              frame_irq,
    output logic              frame_buf,
    output logic              field_err
);
    localparam int unsigned BPW  = DATA_W / 8;
    localparam int unsigned YW_W = (Y_WORDS > 1) ? $clog2(Y_WORDS) : 1;
    localparam int unsigned CW_W = (C_WORDS > 1) ? $clog2(C_WORDS) : 1;
    localparam int unsigned LN_W = $clog2(LINES + 1);
    localparam logic [ADDR_W-1:0] Y_STRIDE   = ADDR_W'(Y_WORDS * BPW);
    localparam logic [ADDR_W-1:0] C_STRIDE   = ADDR_W'(C_WORDS * BPW);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(BPW);
    localparam int unsigned NC = CHROMA_PLANES;

    typedef struct packed {
        logic                         y_we;
        logic [ADDR_W-1:0]            y_addr;
        logic [DATA_W-1:0]            y_data;
        logic [NC-1:0]                c_we;
        logic [NC-1:0][ADDR_W-1:0]    c_addr;
        logic [NC-1:0][DATA_W-1:0]    c_data;
    } wr_t;

    wr_t wr_d, wr_q;

    // Shared control
    logic   sof_take;
    field_e field_in;
    field_e cur_field;
    logic   cur_active;
    logic   buf_sel;

    assign sof_take = sof & enable;
    assign field_in = field_e'(sof_field);

    // Luma path
    logic            y_take;
    logic [YW_W-1:0] y_word;
    logic [LN_W-1:0] y_line;
    logic            y_cur_done;
    logic            y_done_raw;
    logic            y_finish;
    logic            y_overrun;
    logic [ADDR_W-1:0] y_row;
    logic [ADDR_W-1:0] y_base;

    assign y_take = y_valid & enable & cur_active;

    ffa_line_walker #(.WORDS(Y_WORDS), .LINES(LINES)) u_y_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (sof_take),
        .step     (y_take),
        .cur_word (y_word),
        .cur_line (y_line),
        .cur_done (y_cur_done),
        .done_raw (y_done_raw)
    );

    assign y_finish  = y_take && !y_cur_done &&
                       (y_word == YW_W'(Y_WORDS - 1)) && (y_line == LN_W'(LINES - 1));
    assign y_overrun = y_take && y_cur_done;
    assign y_row     = (ADDR_W'(y_line) << 1) | ADDR_W'(cur_field);
    assign y_base    = buf_sel ? y_base_b : y_base_a;

    ffa_frame_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_take   (sof_take),
        .sof_field  (field_in),
        .y_done_raw (y_done_raw),
        .y_overrun  (y_overrun),
        .y_finish   (y_finish),
        .cur_field  (cur_field),
        .cur_active (cur_active),
        .buf_sel    (buf_sel),
        .irq        (frame_irq),
        .irq_buf    (frame_buf),
        .err        (field_err)
    );

    // Chroma paths
    logic [NC-1:0]             c_valid;
    logic [NC-1:0][DATA_W-1:0] c_data_in;
    logic [NC-1:0][ADDR_W-1:0] c_base_a;
    logic [NC-1:0][ADDR_W-1:0] c_base_b;
    logic [NC-1:0]             c_take;
    logic [NC-1:0]             c_we_n;
    logic [NC-1:0][ADDR_W-1:0] c_addr_n;
    logic [NC-1:0]             c_done_raw;

    assign c_valid   = {cr_valid, cb_valid};
    assign c_data_in = {cr_data, cb_data};
    assign c_base_a  = {cr_base_a, cb_base_a};
    assign c_base_b  = {cr_base_b, cb_base_b};

    for (genvar p = 0; p < NC; p++) begin : g_chroma
        logic [CW_W-1:0] c_word;
        logic [LN_W-1:0] c_line;
        logic            c_cur_done;

        assign c_take[p] = c_valid[p] & enable & cur_active;

        ffa_line_walker #(.WORDS(C_WORDS), .LINES(LINES)) u_c_walk (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (sof_take),
            .step     (c_take[p]),
            .cur_word (c_word),
            .cur_line (c_line),
            .cur_done (c_cur_done),
            .done_raw (c_done_raw[p])
        );

        assign c_we_n[p]   = c_take[p] && !c_cur_done && (cur_field == FIELD_ONE);
        assign c_addr_n[p] = (buf_sel ? c_base_b[p] : c_base_a[p])
                             + ADDR_W'(c_line) * C_STRIDE
                             + ADDR_W'(c_word) * WORD_BYTES;

        // R5
        field_two_chroma_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (c_take[p] && !sof_take && cur_field == FIELD_TWO) |=> !wr_q.c_we[p]);

        // R11
        chroma_no_write_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (c_done_raw[p] && !sof_take) |=> !wr_q.c_we[p]);
    end

    always_comb begin
        wr_d        = wr_q;
        wr_d.y_we   = y_take && !y_cur_done;
        wr_d.c_we   = c_we_n;
        if (y_take) begin
            wr_d.y_addr = y_base + y_row * Y_STRIDE + ADDR_W'(y_word) * WORD_BYTES;
            wr_d.y_data = y_data;
        end
        for (int p = 0; p < NC; p++) begin
            if (c_take[p]) begin
                wr_d.c_addr[p] = c_addr_n[p];
                wr_d.c_data[p] = c_data_in[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign y_ready  = enable;
    assign cb_ready = enable;
    assign cr_ready = enable;
    assign y_we     = wr_q.y_we;
    assign y_addr   = wr_q.y_addr;
    assign y_wdata  = wr_q.y_data;
    assign cb_we    = wr_q.c_we[0];
    assign cb_addr  = wr_q.c_addr[0];
    assign cb_wdata = wr_q.c_data[0];
    assign cr_we    = wr_q.c_we[1];
    assign cr_addr  = wr_q.c_addr[1];
    assign cr_wdata = wr_q.c_data[1];

    // R1
    disabled_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(wr_q.y_we || (|wr_q.c_we)));

    // R7
    irq_with_luma_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |-> wr_q.y_we);

    // R11
    luma_no_write_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_done_raw && !sof_take) |=> !wr_q.y_we);
endmodule

// File: tb/ffa_field_assembler_tb.sv
`timescale 1ns/1ps
module ffa_field_assembler_tb;
    localparam int YW = 4;
    localparam int CW = 2;
    localparam int LN = 3;
    localparam int YS = YW * 4;
    localparam int CS = CW * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic sof = 1'b0, sof_field = 1'b0;
    logic y_valid = 1'b0, cb_valid = 1'b0, cr_valid = 1'b0;
    logic [31:0] y_data = '0, cb_data = '0, cr_data = '0;
    logic y_ready, cb_ready, cr_ready;
    logic y_we, cb_we, cr_we;
    logic [31:0] y_addr, cb_addr, cr_addr, y_wdata, cb_wdata, cr_wdata;
    logic frame_irq, frame_buf, field_err;

    logic [31:0] ybase [2] = '{32'h1000, 32'h2000};
    logic [31:0] cbbase[2] = '{32'h3000, 32'h3400};
    logic [31:0] crbase[2] = '{32'h3800, 32'h3C00};

    always #2.5 clk = ~clk;

    ffa_field_assembler #(.ADDR_W(32), .DATA_W(32), .Y_WORDS(YW), .C_WORDS(CW), .LINES(LN)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .y_base_a(ybase[0]), .y_base_b(ybase[1]),
        .cb_base_a(cbbase[0]), .cb_base_b(cbbase[1]),
        .cr_base_a(crbase[0]), .cr_base_b(crbase[1]),
        .sof(sof), .sof_field(sof_field),
        .y_valid(y_valid), .y_data(y_data), .y_ready(y_ready),
        .cb_valid(cb_valid), .cb_data(cb_data), .cb_ready(cb_ready),
        .cr_valid(cr_valid), .cr_data(cr_data), .cr_ready(cr_ready),
        .y_we(y_we), .y_addr(y_addr), .y_wdata(y_wdata),
        .cb_we(cb_we), .cb_addr(cb_addr), .cb_wdata(cb_wdata),
        .cr_we(cr_we), .cr_addr(cr_addr), .cr_wdata(cr_wdata),
        .frame_irq(frame_irq), .frame_buf(frame_buf), .field_err(field_err)
    );

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic        irq;
        logic        ibuf;
        int          cyc;
        string       req;
    } exp_t;

    exp_t yq[$], cbq[$], crq[$];
    int checks = 0, fails = 0, cyc = 0, wr_count = 0;
    logic [31:0] next_data = 32'hA0000000;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic cmp_write(input string plane, ref exp_t q[$], input logic [31:0] a, input logic [31:0] d);
        exp_t e;
        if (q.size() == 0) begin
            chk(1'b0, {"R11 unexpected ", plane, " write"}, a, 32'h0);
            return;
        end
        e = q.pop_front();
        chk(cyc == e.cyc, "R6 write cycle", 32'(cyc), 32'(e.cyc));
        chk(a == e.addr, e.req, a, e.addr);
        chk(d == e.data, "R6 write data", d, e.data);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (y_we) begin
                exp_t e;
                wr_count++;
                if (yq.size() > 0) begin
                    e = yq[0];
                    chk(frame_irq == e.irq, "R7 irq with last luma write", 32'(frame_irq), 32'(e.irq));
                    if (e.irq) chk(frame_buf == e.ibuf, "R8 irq buffer index", 32'(frame_buf), 32'(e.ibuf));
                end
                cmp_write("luma", yq, y_addr, y_wdata);
            end else if (frame_irq) begin
                chk(1'b0, "R7 irq without luma write", 32'h1, 32'h0);
            end
            if (cb_we) begin wr_count++; cmp_write("cb", cbq, cb_addr, cb_wdata); end
            if (cr_we) begin wr_count++; cmp_write("cr", crq, cr_addr, cr_wdata); end
        end
    end

    task automatic idle_inputs();
        sof = 1'b0; y_valid = 1'b0; cb_valid = 1'b0; cr_valid = 1'b0;
    endtask

    // Driver: one field of nlines lines; pushes expected writes.
    task automatic drive_field(input int fld, input int nlines, input bit gaps, input bit irq_exp, input int b);
        for (int l = 0; l < nlines; l++) begin
            for (int w = 0; w < YW; w++) begin
                exp_t e;
                @(posedge clk); #1;
                if (gaps && w == 1) begin
                    idle_inputs();
                    @(posedge clk); #1;
                end
                sof = (l == 0 && w == 0);
                sof_field = fld[0];
                y_valid = 1'b1; y_data = next_data; next_data++;
                e.addr = ybase[b] + 32'((2 * l + fld) * YS + w * 4);
                e.data = y_data;
                e.irq = irq_exp && (l == nlines - 1) && (w == YW - 1);
                e.ibuf = b[0];
                e.cyc = cyc + 1;
                e.req = (fld == 0) ? "R2 field-one luma addr" : "R3 field-two luma addr";
                yq.push_back(e);
                if (w < CW) begin
                    cb_valid = 1'b1; cb_data = next_data; next_data++;
                    cr_valid = 1'b1; cr_data = next_data; next_data++;
                    if (fld == 0) begin
                        e.irq = 1'b0;
                        e.req = "R4 chroma addr";
                        e.addr = cbbase[b] + 32'(l * CS + w * 4); e.data = cb_data; cbq.push_back(e);
                        e.addr = crbase[b] + 32'(l * CS + w * 4); e.data = cr_data; crq.push_back(e);
                    end
                end else begin
                    cb_valid = 1'b0; cr_valid = 1'b0;
                end
            end
        end
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic drain(input string req);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(yq.size() == 0, {req, " luma writes all seen"}, 32'(yq.size()), 0);
        chk(cbq.size() == 0 && crq.size() == 0, {"R5 ", req, " chroma writes all seen"},
            32'(cbq.size() + crq.size()), 0);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!y_we && !cb_we && !cr_we, "R12 write enables low in reset", {29'b0, y_we, cb_we, cr_we}, 0);
        chk(!frame_irq, "R12 irq low in reset", 32'(frame_irq), 0);
        chk(!field_err, "R12 error low after reset", 32'(field_err), 0);
        #1; rst_n = 1'b1;
    endtask

    task automatic finish_up();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        int base_wr;
        do_reset();
        @(negedge clk);
        chk(y_ready == 1'b0 && cb_ready == 1'b0 && cr_ready == 1'b0, "R1 ready low when disabled",
            {29'b0, y_ready, cb_ready, cr_ready}, 0);

        // R1: marker and words while disabled are ignored
        base_wr = wr_count;
        @(posedge clk); #1;
        sof = 1'b1; sof_field = 1'b0; y_valid = 1'b1; cb_valid = 1'b1; cr_valid = 1'b1;
        @(posedge clk); #1;
        sof = 1'b0;
        @(posedge clk); #1;
        idle_inputs();
        enable = 1'b1;
        // R11: words with no start-of-field are ignored
        y_valid = 1'b1; cb_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1; idle_inputs();
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(wr_count == base_wr, "R1 R11 no writes while disabled or before a field", 32'(wr_count), 32'(base_wr));
        chk(y_ready && cb_ready && cr_ready, "R1 ready high when enabled", {29'b0, y_ready, cb_ready, cr_ready}, 3'b111);

        // R8: ping-pong A, B, A
        drive_field(0, LN, 0, 0, 0);
        drive_field(1, LN, 0, 1, 0);
        drive_field(0, LN, 1, 0, 1);
        drive_field(1, LN, 1, 1, 1);
        drive_field(0, LN, 0, 0, 0);
        drive_field(1, LN, 1, 1, 0);
        drain("R8");
        chk(!field_err, "R10 no error on good frames", 32'(field_err), 0);

        // R10: short first field -> error, no irq, buffer B reused; R9 restart after it
        drive_field(0, LN - 1, 0, 0, 1);
        drive_field(1, LN, 0, 0, 1);
        drain("R10 short");
        chk(field_err, "R10 short field sets error", 32'(field_err), 1);
        drive_field(0, LN, 0, 0, 1);
        drive_field(1, LN, 0, 1, 1);
        drain("R9 restart");
        chk(field_err, "R10 error stays set", 32'(field_err), 1);

        // R10: long field after a fresh reset
        do_reset();
        drive_field(0, LN, 0, 0, 0);
        @(posedge clk); #1;
        y_valid = 1'b1; y_data = 32'hDEAD0001;
        @(posedge clk); #1;
        idle_inputs();
        @(negedge clk);
        chk(field_err, "R10 long field sets error", 32'(field_err), 1);
        drive_field(1, LN, 0, 0, 0);
        drive_field(0, LN, 0, 0, 0);
        drive_field(1, LN, 0, 1, 0);
        drain("R11 long");
        finish_up();
    end

    initial begin
        #900000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_up();
    end
endmodule